// File: doc/BRIEF.md
# Host-Side Parallel Converter Read Controller

This block sits on the host side of a four-channel, 16-bit successive-approximation converter that has a parallel output bus. When it accepts a request it presents the requested channel address and pulses chip select and convert low together to start a conversion. It then waits for the converter's busy line to go high and fall again. After that it reads the result, either as one 16-bit word or as two bytes on the low eight data lanes, with a byte-select line choosing which half is driven. Each result is returned with a channel tag. The controller also derives the converter clock from its own clock by a selectable ratio.

The converter applies an address one conversion late. The result of a start therefore belongs to the channel that was issued with the start before it. The controller keeps a one-entry record of the last issued channel and tags each result with it. The first result after reset is marked because its channel is unknown. After the last read strobe the controller waits for a hold-off before it accepts the next start. If busy never completes, a programmable timeout flags the failure and returns the controller to idle.

Top module: `adc_read_ctrl`

## Requirements
- R1: `adc_clk_o` toggles every 2^`div_sel_i` host cycles, so the converter clock period is 2, 4, 8 or 16 host cycles for `div_sel_i` = 0, 1, 2, 3.
- R2: `req_ready_o` is high only while idle. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is low in the cycle after acceptance.
- R3: `adc_addr_o` takes the accepted `req_chan_i` at least one cycle before convert falls. It stays stable from acceptance until the controller is idle again.
- R4: Chip select and convert are low together for exactly START_LOW host cycles. Convert is never low without chip select, and it stays high for the rest of the transaction.
- R5: Read falls only after busy has been seen high and then low. Read is never driven low while busy is high.
- R6: In 16-bit mode (`byte_mode_i`=0 at acceptance) the controller makes one read, low for RD_LOW cycles with byte select 0, and returns all 16 data lanes as `res_data_o`.
- R7: In 8-bit mode (`byte_mode_i`=1) the controller makes two reads, each low for RD_LOW cycles. The first has byte select 0 and supplies result bits 7:0 from lanes 7:0. The second has byte select 1 and supplies bits 15:8 from lanes 7:0. Read stays high for at least RD_HIGH cycles between the two reads, and byte select does not change while read is low.
- R8: Convert falls no sooner than 3×ratio host cycles after the last read rises, where ratio is 2^`div_sel_i`. This is 1.5 converter clocks.
- R9: `res_valid_o` is a one-cycle pulse. `res_chan_o` carries the channel of the start before the one that produced the result. `res_first_o` is 1 only for the first start after reset.
- R10: If busy has not fallen when the wait count reaches `timeout_lim_i`, `timeout_o` pulses for one cycle and the controller returns to idle with no result. This is 5 + `timeout_lim_i` host edges after the accepting edge, counting the accepting edge as the first.
- R11: During reset chip select, convert and read are high, byte select is 0, `req_ready_o` is 1, and `res_valid_o` and `timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Converter clock divide select (ratio 2^sel) |
| timeout_lim_i | input | TO_W | Busy wait limit in host cycles |
| req_valid_i | input | 1 | Conversion request |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_chan_i | input | CH_W | Channel address for this start |
| byte_mode_i | input | 1 | 1 selects two 8-bit reads |
| adc_clk_o | output | 1 | Divided converter clock |
| adc_cs_no | output | 1 | Chip select, active low |
| adc_conv_no | output | 1 | Convert start, active low |
| adc_rd_no | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Byte select, 1 selects the high byte |
| adc_addr_o | output | CH_W | Channel address to converter |
| adc_busy_i | input | 1 | Converter busy |
| adc_data_i | input | DW | Converter data lanes |
| res_valid_o | output | 1 | Result pulse |
| res_data_o | output | DW | Two's complement result |
| res_chan_o | output | CH_W | Channel the result belongs to |
| res_first_o | output | 1 | Result has no known channel |
| timeout_o | output | 1 | Busy did not complete in time |

## Verification
The bench keeps a behavioural converter model. The model raises busy on the edge after it sees the start pulse, holds it for 17 cycles, and latches the address to use at the next start. Each result is awaited by polling on falling edges for the `res_valid_o` pulse. That pulse comes one cycle after the last read strobe completes its RD_LOW low cycles. The bench then compares the result against the word the model was given and against the previous request's channel. Strobe widths, the address at convert fall, the hold-off and the clock toggle interval are measured in host cycles by a monitor that samples one time unit after each falling edge. The timeout flag is checked at exactly 5 + limit host edges after the accepting edge.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_START, ST_WAIT, ST_RD1, ST_GAP, ST_RD2, ST_DONE, ST_HOLD
  } state_e;

  function automatic logic [3:0] div_ratio(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction
endpackage

// File: rtl/adcrd_clkdiv.sv
module adcrd_clkdiv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  output logic [3:0] ratio_o,
  output logic       adc_clk_o
);
  import adcrd_pkg::*;

  logic [3:0] cnt_q;
  logic       clk_q;

  assign ratio_o   = div_ratio(div_sel_i);
  assign adc_clk_o = clk_q;

  // >= keeps the counter sane when the ratio shrinks mid-count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q >= ratio_o - 4'd1) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 4'd1;
    end
  end
endmodule

// File: rtl/adcrd_fsm.sv
module adcrd_fsm #(
  parameter int START_LOW = 2,
  parameter int RD_LOW    = 3,
  parameter int RD_HIGH   = 2,
  parameter int TO_W      = 12,
  parameter int CH_W      = 2,
  parameter int DW        = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      ratio_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [CH_W-1:0] req_chan_i,
  input  logic            byte_mode_i,
  output logic            adc_cs_no,
  output logic            adc_conv_no,
  output logic            adc_rd_no,
  output logic            adc_byte_o,
  output logic [CH_W-1:0] adc_addr_o,
  input  logic            adc_busy_i,
  input  logic [DW-1:0]   adc_data_i,
  output logic            res_valid_o,
  output logic [DW-1:0]   res_data_o,
  output logic [CH_W-1:0] res_chan_o,
  output logic            res_first_o,
  output logic            timeout_o
);
  import adcrd_pkg::*;

  localparam int CNT_W = (TO_W > 8) ? TO_W : 8;
  localparam int HALF  = DW / 2;
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_LOW - 1);
  localparam logic [CNT_W-1:0] RDL_LAST   = CNT_W'(RD_LOW - 1);
  localparam logic [CNT_W-1:0] RDH_LAST   = CNT_W'(RD_HIGH - 1);

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  hold_last;
  logic [CH_W-1:0]   addr_q, prev_q, tag_q;
  logic              have_prev_q, first_q, narrow_q, seen_q, to_q;
  logic [HALF-1:0]   lo_q;
  logic [DW-1:0]     res_q;

  assign hold_last = CNT_W'(ratio_i) + CNT_W'(ratio_i) + CNT_W'(ratio_i) - CNT_W'(1);

  assign req_ready_o = (state_q == ST_IDLE);
  assign adc_conv_no = (state_q != ST_START);
  assign adc_rd_no   = !(state_q == ST_RD1 || state_q == ST_RD2);
  assign adc_cs_no   = !(state_q == ST_START || state_q == ST_RD1 ||
                         state_q == ST_GAP   || state_q == ST_RD2);
  assign adc_byte_o  = (state_q == ST_GAP || state_q == ST_RD2);
  assign adc_addr_o  = addr_q;
  assign res_valid_o = (state_q == ST_DONE);
  assign res_data_o  = res_q;
  assign res_chan_o  = tag_q;
  assign res_first_o = first_q;
  assign timeout_o   = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      prev_q      <= '0;
      tag_q       <= '0;
      have_prev_q <= 1'b0;
      first_q     <= 1'b0;
      narrow_q    <= 1'b0;
      seen_q      <= 1'b0;
      to_q        <= 1'b0;
      lo_q        <= '0;
      res_q       <= '0;
    end else begin
      to_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q   <= req_chan_i;
          narrow_q <= byte_mode_i;
          state_q  <= ST_SETUP;
        end
        ST_SETUP: begin
          // converter applies the address one start late: shift the record
          cnt_q       <= '0;
          tag_q       <= prev_q;
          first_q     <= !have_prev_q;
          prev_q      <= addr_q;
          have_prev_q <= 1'b1;
          state_q     <= ST_START;
        end
        ST_START: begin
          if (cnt_q == START_LAST) begin
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            state_q <= ST_WAIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT: begin
          if (adc_busy_i) seen_q <= 1'b1;
          if (seen_q && !adc_busy_i) begin
            cnt_q   <= '0;
            state_q <= ST_RD1;
          end else if (cnt_q == CNT_W'(timeout_lim_i)) begin
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RD1: begin
          if (cnt_q == RDL_LAST) begin
            cnt_q <= '0;
            if (narrow_q) begin
              lo_q    <= adc_data_i[HALF-1:0];
              state_q <= ST_GAP;
            end else begin
              res_q   <= adc_data_i;
              state_q <= ST_DONE;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_GAP: begin
          if (cnt_q == RDH_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_RD2;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RD2: begin
          if (cnt_q == RDL_LAST) begin
            cnt_q   <= '0;
            res_q   <= {adc_data_i[HALF-1:0], lo_q};
            state_q <= ST_DONE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: begin
          cnt_q   <= '0;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt_q >= hold_last) state_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
  parameter int START_LOW = 2,
  parameter int RD_LOW    = 3,
  parameter int RD_HIGH   = 2,
  parameter int TO_W      = 12,
  parameter int CH_W      = 2,
  parameter int DW        = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      div_sel_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [CH_W-1:0] req_chan_i,
  input  logic            byte_mode_i,
  output logic            adc_clk_o,
  output logic            adc_cs_no,
  output logic            adc_conv_no,
  output logic            adc_rd_no,
  output logic            adc_byte_o,
  output logic [CH_W-1:0] adc_addr_o,
  input  logic            adc_busy_i,
  input  logic [DW-1:0]   adc_data_i,
  output logic            res_valid_o,
  output logic [DW-1:0]   res_data_o,
  output logic [CH_W-1:0] res_chan_o,
  output logic            res_first_o,
  output logic            timeout_o
);
  logic [3:0] ratio;

  adcrd_clkdiv u_clkdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_sel_i),
    .ratio_o   (ratio),
    .adc_clk_o (adc_clk_o)
  );

  adcrd_fsm #(
    .START_LOW (START_LOW),
    .RD_LOW    (RD_LOW),
    .RD_HIGH   (RD_HIGH),
    .TO_W      (TO_W),
    .CH_W      (CH_W),
    .DW        (DW)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ratio_i       (ratio),
    .timeout_lim_i (timeout_lim_i),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_chan_i    (req_chan_i),
    .byte_mode_i   (byte_mode_i),
    .adc_cs_no     (adc_cs_no),
    .adc_conv_no   (adc_conv_no),
    .adc_rd_no     (adc_rd_no),
    .adc_byte_o    (adc_byte_o),
    .adc_addr_o    (adc_addr_o),
    .adc_busy_i    (adc_busy_i),
    .adc_data_i    (adc_data_i),
    .res_valid_o   (res_valid_o),
    .res_data_o    (res_data_o),
    .res_chan_o    (res_chan_o),
    .res_first_o   (res_first_o),
    .timeout_o     (timeout_o)
  );
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk #(
  parameter int CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            adc_cs_no,
  input logic            adc_conv_no,
  input logic            adc_rd_no,
  input logic            adc_byte_o,
  input logic [CH_W-1:0] adc_addr_o,
  input logic            adc_busy_i,
  input logic            res_valid_o,
  input logic            timeout_o
);
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> adc_cs_no && adc_conv_no && adc_rd_no); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(adc_addr_o)); // R3
  AST_CONV_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_conv_no |-> !adc_cs_no); // R4
  AST_RD_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rd_no) |-> !adc_busy_i); // R5
  AST_BYTE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_rd_no && $past(!adc_rd_no)) |-> $stable(adc_byte_o)); // R7
  AST_NO_RD_IN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> adc_conv_no); // R8
  AST_RESULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R9
  AST_TIMEOUT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !res_valid_o && req_ready_o); // R10
endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(.CH_W(CH_W)) u_chk (.*);

// File: tb/adc_read_ctrl_bench.sv
`timescale 1ns/1ps
module adc_read_ctrl_bench;
  localparam int START_LOW = 2;
  localparam int RD_LOW    = 3;
  localparam int RD_HIGH   = 2;
  localparam int TO_W      = 12;
  localparam int CONV_CYC  = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic [11:0] to_lim = 12'd500;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = 2'd0;
  logic        byte_mode = 1'b0;
  logic        adc_clk, cs_n, conv_n, rd_n, byte_sel;
  logic [1:0]  addr;
  logic        busy;
  logic [15:0] data;
  logic        res_valid, res_first, timeout;
  logic [15:0] res_data;
  logic [1:0]  res_chan;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adc_read_ctrl u_adc_read_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel), .timeout_lim_i(to_lim),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_chan_i(req_chan),
    .byte_mode_i(byte_mode), .adc_clk_o(adc_clk), .adc_cs_no(cs_n),
    .adc_conv_no(conv_n), .adc_rd_no(rd_n), .adc_byte_o(byte_sel),
    .adc_addr_o(addr), .adc_busy_i(busy), .adc_data_i(data),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_chan_o(res_chan),
    .res_first_o(res_first), .timeout_o(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic        stuck = 1'b0;
  logic [15:0] next_word = 16'h0;
  logic [15:0] pend_word, word_q;
  logic        was_start;
  int          conv_left;

  assign data = byte_sel ? {8'hA5, word_q[15:8]} : word_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; was_start <= 1'b0; conv_left <= 0;
      pend_word <= '0; word_q <= '0;
    end else begin
      was_start <= !cs_n && !conv_n;
      if (!cs_n && !conv_n && !was_start && !busy) begin
        busy <= 1'b1; conv_left <= CONV_CYC; pend_word <= next_word;
      end else if (busy && !stuck) begin
        if (conv_left <= 1) begin busy <= 1'b0; word_q <= pend_word; end
        else conv_left <= conv_left - 1;
      end
    end
  end

  function automatic int exp_ratio(input logic [1:0] s);
    return 1 << s;
  endfunction

  // protocol monitor, sampled 1 ns after the falling edge
  logic [1:0] cur_chan = 2'd0;
  bit prev_conv_n = 1, prev_rd_n = 1, prev_clk = 0;
  logic [1:0] last_div = 2'd0;
  int cyc = 0, conv_fall = 0, rd_fall = 0, last_rd_rise = -1000, hold_ratio = 1;
  int rd_idx = 0, last_tog = 0, tog_seen = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      cyc++;
      if (prev_conv_n && !conv_n) begin
        chk(cyc - last_rd_rise >= 3 * hold_ratio, "R8 hold-off", cyc - last_rd_rise, 3 * hold_ratio);
        chk(addr == cur_chan, "R3 address at start", addr, cur_chan);
        conv_fall = cyc; rd_idx = 0;
      end
      if (!prev_conv_n && conv_n)
        chk(cyc - conv_fall == START_LOW, "R4 start width", cyc - conv_fall, START_LOW);
      if (prev_rd_n && !rd_n) begin
        chk(!busy, "R5 read while busy", busy, 0);
        if (rd_idx == 1)
          chk(cyc - last_rd_rise >= RD_HIGH, "R7 read high gap", cyc - last_rd_rise, RD_HIGH);
        chk(byte_sel == (rd_idx == 1), "R7 byte select", byte_sel, rd_idx == 1);
        rd_fall = cyc;
      end
      if (!prev_rd_n && rd_n) begin
        chk(cyc - rd_fall == RD_LOW, "R6 read width", cyc - rd_fall, RD_LOW);
        last_rd_rise = cyc; hold_ratio = exp_ratio(div_sel); rd_idx++;
      end
      if (div_sel != last_div) tog_seen = 0;
      if (adc_clk != prev_clk) begin
        if (tog_seen >= 1)
          chk(cyc - last_tog == exp_ratio(div_sel), "R1 clock toggle", cyc - last_tog, exp_ratio(div_sel));
        last_tog = cyc; tog_seen++;
      end
      last_div = div_sel;
      prev_conv_n = conv_n; prev_rd_n = rd_n; prev_clk = adc_clk;
    end
  end

  logic [1:0] prev_chan = 2'd0;
  bit have_prev = 0;

  task automatic do_req(input logic [1:0] ch, input logic mode);
    int n;
    bit got;
    logic [15:0] w;
    w = 16'($urandom);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    next_word = w; cur_chan = ch;
    req_valid = 1'b1; req_chan = ch; byte_mode = mode;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready after accept", req_ready, 0);
    n = 1; got = 0;
    while (!got && n < 2000) begin
      if (res_valid) begin
        got = 1;
        chk(res_data == w, mode ? "R7 8-bit result" : "R6 16-bit result", res_data, w);
        chk(res_first == !have_prev, "R9 first flag", res_first, !have_prev);
        if (have_prev) chk(res_chan == prev_chan, "R9 channel tag", res_chan, prev_chan);
        @(negedge clk);
        chk(!res_valid, "R9 single pulse", res_valid, 0);
      end else begin
        @(negedge clk); n++;
      end
    end
    if (!got) chk(0, "R9 result missing", 0, 1);
    prev_chan = ch; have_prev = 1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n && conv_n && rd_n, "R11 strobes idle", {cs_n, conv_n, rd_n}, 7);
    chk(!byte_sel, "R11 byte select", byte_sel, 0);
    chk(req_ready, "R11 ready", req_ready, 1);
    chk(!res_valid && !timeout, "R11 no result", {res_valid, timeout}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    do_req(2'd2, 1'b0);            // first after reset
    do_req(2'd1, 1'b1);
    do_req(2'd1, 1'b1);            // same channel twice
    div_sel = 2'd3;
    repeat (40) @(negedge clk);
    do_req(2'd3, 1'b1);            // slowest clock, longest hold-off
    do_req(2'd0, 1'b0);

    // R10 timeout with busy stuck high
    begin
      int n;
      bit seen_res;
      to_lim = 12'd40; stuck = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_chan = 2'd2; req_valid = 1'b1; req_chan = 2'd2;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1; seen_res = 0;
      while (!timeout && n < 500) begin
        if (res_valid) seen_res = 1;
        @(negedge clk); n++;
      end
      chk(timeout, "R10 timeout raised", timeout, 1);
      chk(n == 45, "R10 timeout cycle", n, 45);
      chk(!seen_res && !res_valid, "R10 no result", seen_res, 0);
      chk(req_ready, "R10 back to idle", req_ready, 1);
      @(negedge clk);
      chk(!timeout, "R10 single pulse", timeout, 0);
      prev_chan = 2'd2; have_prev = 1;
      stuck = 1'b0; to_lim = 12'd500;
      repeat (40) @(negedge clk);
    end

    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 0) begin
        div_sel = 2'($urandom_range(0, 3));
        repeat (40) @(negedge clk);
      end
      do_req(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule